// File: doc/BRIEF.md
# Processor power mode controller

This block decides which power mode a processor core is in and drives the enables that make that mode real. It holds one of five operating modes (full-on, active, sleep, deep-sleep, hibernate), plus a transient reset-sequence state used when the chip leaves hibernate. Software asks for a mode change with a strobe and a 3-bit code. Hardware events bring the part back out of the low-power modes.

In each mode the controller sets a fixed pattern on its outputs: core clock enable, system clock enable, PLL enable, core regulator enable, an I/O three-state control, a permit for system DMA into L1 memory, and a reset-sequence trigger. Where the controller lands after a wake depends on which mode it is leaving. From sleep it also depends on the PLL bypass input. A hibernate wake never resumes the old mode. It raises the reset-sequence output for `RST_CYCLES` cycles with the regulator on, and then settles in full-on.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After asynchronous reset the mode is full-on (`mode_o`=0). In full-on, core clock, system clock, PLL, regulator and DMA permit are all 1, and three-state and reset-sequence are 0.
- R2: Active mode (`mode_o`=1) runs both clocks with the regulator on and DMA permitted. Request code 1 enters it with the PLL enabled. Request code 5 enters it with the PLL disabled.
- R3: Sleep mode (`mode_o`=2) gates only the core clock. The system clock, PLL and regulator stay on, and the DMA-to-L1 permit is 0.
- R4: A request (`req_valid_i`=1, codes 0 full-on, 1 active, 2 sleep, 3 deep-sleep, 4 hibernate, 5 active without PLL) is taken only in full-on or active, and the new mode shows after the clock edge that samples the strobe. Codes 6 and 7, and any request in another mode, leave the mode unchanged.
- R5: In sleep, `wake_evt_i` moves to full-on when `bypass_i`=0 and to active when `bypass_i`=1. `rtc_irq_i` and requests do not end sleep.
- R6: Deep-sleep (`mode_o`=3) gates both clocks and keeps the PLL and regulator on, with DMA permit 0.
- R7: Deep-sleep ends only on `rtc_irq_i`, which goes to active, or on `reset_pin_i`, which goes to full-on. `wake_evt_i` and requests have no effect there.
- R8: Hibernate (`mode_o`=4) drives both clock enables, the PLL enable and the regulator enable to 0, and drives the three-state control to 1.
- R9: In hibernate, any bit of `hib_wake_i`, `rtc_irq_i` or `reset_pin_i` moves to the reset-sequence state (`mode_o`=6). In that state the regulator and PLL are 1, both clocks are 0, and `rst_seq_o` is 1.
- R10: The reset-sequence state lasts exactly `RST_CYCLES` cycles and then goes to full-on. Requests and `reset_pin_i` do not shorten it.
- R11: `reset_pin_i` forces full-on from full-on, active, sleep and deep-sleep. It wins over a simultaneous request, wake event or RTC interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Software mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| bypass_i | input | 1 | PLL bypass bit, selects the sleep wake target |
| wake_evt_i | input | 1 | Enabled wakeup event (ends sleep) |
| rtc_irq_i | input | 1 | RTC interrupt |
| reset_pin_i | input | 1 | External reset pin, synchronous level |
| hib_wake_i | input | NUM_WAKE | Hibernate wake sources, one per bit |
| mode_o | output | 3 | Current mode code |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| pll_en_o | output | 1 | PLL enable |
| vreg_en_o | output | 1 | Core regulator enable |
| io_tristate_o | output | 1 | Three-state all external pins |
| dma_l1_ok_o | output | 1 | System DMA to L1 permitted |
| rst_seq_o | output | 1 | Hardware reset sequence in progress |

## Verification
The assertions assume that every input is synchronous to `clk_i` and holds a stable level through each cycle. They also assume that `reset_pin_i` is a level the controller samples, not an asynchronous event. The bench changes every input only on the falling clock edge and holds it for exactly one cycle. It asserts wake sources, RTC and reset pin together only in steps written to test priority, so each property's precondition appears in isolation as well as in conflict.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    M_FULL   = 3'd0,
    M_ACTIVE = 3'd1,
    M_SLEEP  = 3'd2,
    M_DEEP   = 3'd3,
    M_HIBER  = 3'd4,
    M_RSEQ   = 3'd6
  } pmode_e;

  localparam logic [2:0] REQ_FULL      = 3'd0;
  localparam logic [2:0] REQ_ACT       = 3'd1;
  localparam logic [2:0] REQ_SLEEP     = 3'd2;
  localparam logic [2:0] REQ_DEEP      = 3'd3;
  localparam logic [2:0] REQ_HIBER     = 3'd4;
  localparam logic [2:0] REQ_ACT_NOPLL = 3'd5;

  typedef struct packed {
    logic cclk;
    logic sclk;
    logic pll;
    logic vreg;
    logic io_tri;
    logic dma_ok;
    logic rseq;
  } pctl_t;
endpackage

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic last_o
);
  localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] LOAD = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_mode_i,
  input  logic       bypass_i,
  input  logic       wake_evt_i,
  input  logic       rtc_irq_i,
  input  logic       reset_pin_i,
  input  logic       hib_wake_any_i,
  input  logic       tmr_last_i,
  output pmode_e     mode_o,
  output logic       pll_off_o,
  output logic       tmr_start_o
);
  pmode_e st_q, st_d;
  logic   off_q, off_d;

  always_comb begin
    st_d        = st_q;
    off_d       = 1'b0;
    tmr_start_o = 1'b0;
    unique case (st_q)
      M_FULL, M_ACTIVE: begin
        off_d = off_q;
        if (reset_pin_i) begin
          st_d  = M_FULL;
          off_d = 1'b0;
        end else if (req_valid_i) begin
          off_d = 1'b0;
          case (req_mode_i)
            REQ_FULL:      st_d = M_FULL;
            REQ_ACT:       st_d = M_ACTIVE;
            REQ_ACT_NOPLL: begin st_d = M_ACTIVE; off_d = 1'b1; end
            REQ_SLEEP:     st_d = M_SLEEP;
            REQ_DEEP:      st_d = M_DEEP;
            REQ_HIBER:     st_d = M_HIBER;
            default:       off_d = off_q;  // unused codes
          endcase
        end
      end
      M_SLEEP: begin
        if (reset_pin_i)     st_d = M_FULL;
        else if (wake_evt_i) st_d = bypass_i ? M_ACTIVE : M_FULL;
      end
      M_DEEP: begin
        if (reset_pin_i)    st_d = M_FULL;
        else if (rtc_irq_i) st_d = M_ACTIVE;
      end
      M_HIBER: begin
        if (hib_wake_any_i || rtc_irq_i || reset_pin_i) begin
          st_d        = M_RSEQ;
          tmr_start_o = 1'b1;
        end
      end
      M_RSEQ: begin
        if (tmr_last_i) st_d = M_FULL;
      end
      default: st_d = M_FULL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= M_FULL;
      off_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      off_q <= off_d;
    end
  end

  assign mode_o    = st_q;
  assign pll_off_o = off_q;
endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
  import pwr_mode_pkg::*;
(
  input  pmode_e mode_i,
  input  logic   pll_off_i,
  output pctl_t  ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (mode_i)
      M_FULL:   ctl_o = '{cclk:1'b1, sclk:1'b1, pll:1'b1,       vreg:1'b1, io_tri:1'b0, dma_ok:1'b1, rseq:1'b0};
      M_ACTIVE: ctl_o = '{cclk:1'b1, sclk:1'b1, pll:!pll_off_i, vreg:1'b1, io_tri:1'b0, dma_ok:1'b1, rseq:1'b0};
      M_SLEEP:  ctl_o = '{cclk:1'b0, sclk:1'b1, pll:1'b1,       vreg:1'b1, io_tri:1'b0, dma_ok:1'b0, rseq:1'b0};
      M_DEEP:   ctl_o = '{cclk:1'b0, sclk:1'b0, pll:1'b1,       vreg:1'b1, io_tri:1'b0, dma_ok:1'b0, rseq:1'b0};
      M_HIBER:  ctl_o = '{cclk:1'b0, sclk:1'b0, pll:1'b0,       vreg:1'b0, io_tri:1'b1, dma_ok:1'b0, rseq:1'b0};
      M_RSEQ:   ctl_o = '{cclk:1'b0, sclk:1'b0, pll:1'b1,       vreg:1'b1, io_tri:1'b0, dma_ok:1'b0, rseq:1'b1};
      default:  ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NUM_WAKE   = 8,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [2:0]          req_mode_i,
  input  logic                bypass_i,
  input  logic                wake_evt_i,
  input  logic                rtc_irq_i,
  input  logic                reset_pin_i,
  input  logic [NUM_WAKE-1:0] hib_wake_i,
  output logic [2:0]          mode_o,
  output logic                cclk_en_o,
  output logic                sclk_en_o,
  output logic                pll_en_o,
  output logic                vreg_en_o,
  output logic                io_tristate_o,
  output logic                dma_l1_ok_o,
  output logic                rst_seq_o
);
  pmode_e mode;
  pctl_t  ctl;
  logic   pll_off, tmr_start, tmr_last;

  pwr_mode_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_mode_i     (req_mode_i),
    .bypass_i       (bypass_i),
    .wake_evt_i     (wake_evt_i),
    .rtc_irq_i      (rtc_irq_i),
    .reset_pin_i    (reset_pin_i),
    .hib_wake_any_i (|hib_wake_i),
    .tmr_last_i     (tmr_last),
    .mode_o         (mode),
    .pll_off_o      (pll_off),
    .tmr_start_o    (tmr_start)
  );

  pwr_rst_timer #(.CYCLES(RST_CYCLES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .last_o  (tmr_last)
  );

  pwr_out_decode u_dec (
    .mode_i    (mode),
    .pll_off_i (pll_off),
    .ctl_o     (ctl)
  );

  assign mode_o        = mode;
  assign cclk_en_o     = ctl.cclk;
  assign sclk_en_o     = ctl.sclk;
  assign pll_en_o      = ctl.pll;
  assign vreg_en_o     = ctl.vreg;
  assign io_tristate_o = ctl.io_tri;
  assign dma_l1_ok_o   = ctl.dma_ok;
  assign rst_seq_o     = ctl.rseq;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int unsigned NUM_WAKE   = 8,
  parameter int unsigned RST_CYCLES = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                bypass_i,
  input logic                wake_evt_i,
  input logic                rtc_irq_i,
  input logic                reset_pin_i,
  input logic [NUM_WAKE-1:0] hib_wake_i,
  input logic [2:0]          mode_o,
  input logic                cclk_en_o,
  input logic                sclk_en_o,
  input logic                pll_en_o,
  input logic                vreg_en_o,
  input logic                io_tristate_o,
  input logic                dma_l1_ok_o,
  input logic                rst_seq_o
);
  int unsigned seq_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seq_cnt_q <= 0;
    else if (mode_o == 3'd6) seq_cnt_q <= seq_cnt_q + 1;
    else                    seq_cnt_q <= 0;
  end

  a_r3_sleep_no_dma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2) |-> (!dma_l1_ok_o && !cclk_en_o && sclk_en_o));

  a_r8_hiber_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> (io_tristate_o && !vreg_en_o && !pll_en_o && !sclk_en_o));

  a_r9_seq_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_seq_o |-> (vreg_en_o && !cclk_en_o && !io_tristate_o));

  a_r5_sleep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && !wake_evt_i && !reset_pin_i) |=> (mode_o == 3'd2));

  a_r5_sleep_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && wake_evt_i && !reset_pin_i) |=> (mode_o == ($past(bypass_i) ? 3'd1 : 3'd0)));

  a_r7_deep_rtc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && rtc_irq_i && !reset_pin_i) |=> (mode_o == 3'd1));

  a_r7_deep_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && !rtc_irq_i && !reset_pin_i) |=> (mode_o == 3'd3));

  a_r11_pin_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o <= 3'd3 && reset_pin_i) |=> (mode_o == 3'd0));

  a_r9_hiber_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && ((|hib_wake_i) || rtc_irq_i || reset_pin_i)) |=> (mode_o == 3'd6 && rst_seq_o));

  a_r4_hiber_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4 && !(|hib_wake_i) && !rtc_irq_i && !reset_pin_i) |=> (mode_o == 3'd4));

  a_r10_seq_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd6) |-> (seq_cnt_q < RST_CYCLES));

  a_r10_seq_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd6 && seq_cnt_q != 0) |-> (seq_cnt_q == RST_CYCLES && mode_o == 3'd0));

  wire unused_ok = req_valid_i;
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.NUM_WAKE(NUM_WAKE), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .bypass_i      (bypass_i),
  .wake_evt_i    (wake_evt_i),
  .rtc_irq_i     (rtc_irq_i),
  .reset_pin_i   (reset_pin_i),
  .hib_wake_i    (hib_wake_i),
  .mode_o        (mode_o),
  .cclk_en_o     (cclk_en_o),
  .sclk_en_o     (sclk_en_o),
  .pll_en_o      (pll_en_o),
  .vreg_en_o     (vreg_en_o),
  .io_tristate_o (io_tristate_o),
  .dma_l1_ok_o   (dma_l1_ok_o),
  .rst_seq_o     (rst_seq_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int unsigned NW = 8;
  localparam int unsigned RN = 6;

  localparam logic [2:0] MF = 3'd0, MA = 3'd1, MS = 3'd2, MD = 3'd3, MH = 3'd4, MR = 3'd6;
  // {cclk, sclk, pll, vreg, io_tri, dma_ok, rseq}
  localparam logic [6:0] C_FULL = 7'b1111010;
  localparam logic [6:0] C_ANOP = 7'b1101010;
  localparam logic [6:0] C_SLP  = 7'b0111000;
  localparam logic [6:0] C_DEEP = 7'b0011000;
  localparam logic [6:0] C_HIB  = 7'b0000100;
  localparam logic [6:0] C_SEQ  = 7'b0011001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rv = 1'b0, byp = 1'b0, we = 1'b0, rtc = 1'b0, rp = 1'b0;
  logic [2:0] rm = 3'd0;
  logic [NW-1:0] hw = '0;
  logic [2:0] mode;
  logic cc, sc, pl, vr, tri_o, dma, rs;

  int total = 0, bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [9:0] e_cur;
  string      t_cur;
  bit         done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_WAKE(NW), .RST_CYCLES(RN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_mode_i(rm), .bypass_i(byp),
    .wake_evt_i(we), .rtc_irq_i(rtc), .reset_pin_i(rp), .hib_wake_i(hw),
    .mode_o(mode), .cclk_en_o(cc), .sclk_en_o(sc), .pll_en_o(pl), .vreg_en_o(vr),
    .io_tristate_o(tri_o), .dma_l1_ok_o(dma), .rst_seq_o(rs)
  );

  wire [9:0] obs = {mode, cc, sc, pl, vr, tri_o, dma, rs};

  // monitor: compares one cycle after each driven step
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      e_cur = exp_q.pop_front();
      t_cur = tag_q.pop_front();
      total++;
      if (obs !== e_cur) begin
        bad++;
        $display("FAIL %s got=%b expected=%b", t_cur, obs, e_cur);
      end
    end
  end

  task automatic step(input logic v, input logic [2:0] m, input logic b, input logic w,
                      input logic r, input logic p, input logic [NW-1:0] h,
                      input logic [2:0] em, input logic [6:0] ec, input string tag);
    @(negedge clk);
    rv = v; rm = m; byp = b; we = w; rtc = r; rp = p; hw = h;
    exp_q.push_back({em, ec});
    tag_q.push_back(tag);
  endtask

  task automatic req(input logic [2:0] m, input logic [2:0] em, input logic [6:0] ec, input string tag);
    step(1'b1, m, 1'b0, 1'b0, 1'b0, 1'b0, '0, em, ec, tag);
  endtask

  task automatic idle(input logic [2:0] em, input logic [6:0] ec, input string tag);
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0, em, ec, tag);
  endtask

  task automatic seq_tail(input string tag);
    for (int i = 0; i < int'(RN) - 1; i++) begin
      if (i == 1) step(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, '0, MR, C_SEQ, "R10 pin/req ignored in seq");
      else        idle(MR, C_SEQ, tag);
    end
    idle(MF, C_FULL, "R10 seq ends in full-on");
  endtask

  initial begin
    #3;
    total++;
    if ({mode, cc, sc, pl, vr, tri_o, dma, rs} !== {MF, C_FULL}) begin
      bad++;
      $display("FAIL R1 reset got=%b expected=%b", obs, {MF, C_FULL});
    end
    @(negedge clk); rst_n = 1'b1;

    idle(MF, C_FULL, "R1 full-on idle");
    req(3'd1, MA, C_FULL, "R2 active pll on");
    idle(MA, C_FULL, "R2 active hold");
    req(3'd2, MS, C_SLP, "R3 sleep");
    req(3'd0, MS, C_SLP, "R4 request ignored in sleep");
    step(1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, '0, MS, C_SLP, "R5 rtc ignored in sleep");
    step(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, MF, C_FULL, "R5 wake bypass=0 full");
    req(3'd1, MA, C_FULL, "R4 active from full");
    req(3'd2, MS, C_SLP, "R4 sleep from active");
    step(1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, '0, MA, C_FULL, "R5 wake bypass=1 active");
    req(3'd3, MD, C_DEEP, "R6 deep from active");
    step(1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, '0, MD, C_DEEP, "R7 wake/req ignored in deep");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, '0, MA, C_FULL, "R7 rtc deep to active");
    req(3'd3, MD, C_DEEP, "R6 deep again");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, '0, MF, C_FULL, "R7 R11 pin wins deep");
    req(3'd5, MA, C_ANOP, "R2 active pll off");
    req(3'd6, MA, C_ANOP, "R4 code 6 ignored");
    req(3'd7, MA, C_ANOP, "R4 code 7 ignored");
    req(3'd2, MS, C_SLP, "R3 sleep pll back on");
    step(1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, '0, MF, C_FULL, "R11 pin beats wake in sleep");
    step(1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, '0, MF, C_FULL, "R11 pin beats request");
    req(3'd4, MH, C_HIB, "R8 hibernate");
    step(1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, '0, MH, C_HIB, "R8 request/wake ignored in hibernate");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, NW'(8), MR, C_SEQ, "R9 wake source bit exit");
    seq_tail("R10 seq hold");
    req(3'd4, MH, C_HIB, "R8 hibernate 2");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, '0, MR, C_SEQ, "R9 rtc exit");
    seq_tail("R10 seq hold rtc");
    req(3'd1, MA, C_FULL, "R2 active");
    req(3'd4, MH, C_HIB, "R8 hibernate from active");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, '0, MR, C_SEQ, "R9 pin exit");
    seq_tail("R10 seq hold pin");
    idle(MF, C_FULL, "R1 full-on settled");

    @(negedge clk);
    rv = 0; we = 0; rtc = 0; rp = 0; hw = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule